// File: doc/BRIEF.md
# Execute-Stage Arithmetic Unit with Operation Decode and Branch Target Adder

This block is the arithmetic heart of a 32-bit single-cycle processor for a small load/store instruction subset. It takes the two register operands, the sign-extended 16-bit immediate, the 6-bit function field and a 2-bit instruction class from the main decoder. From these it produces a 32-bit result and a flag that is high when that result is zero. The class code fixes the operation for memory accesses (add, forming an address) and for branch-on-equal (subtract, so the zero flag reports equality). Only for register-format instructions does the function field choose the operation.

A select input replaces the second register operand with the immediate. Shifts take their distance from immediate bits 10 to 6. Next to the arithmetic unit, a small adder forms an 8-bit branch destination from the incremented program counter and the immediate scaled by four. The block has no state. The clock and active-low reset pins exist so that it fits the pipeline wrapper, but they do not affect the outputs.

Top module: `exec_stage`

## Requirements
- R1: With class code `aluop_i` = 2'b00 (load/store), `result_o` equals `opa_i` plus the selected second operand, modulo 2^32.
- R2: With `aluop_i` = 2'b01 (branch-on-equal), `result_o` equals `opa_i` minus the selected second operand, so `zero_o` is 1 exactly when the two operands are equal.
- R3: When `aluop_i[1]` is 1, `funct_i` chooses the operation: 32 and 33 add, 34 and 35 subtract, 36 gives bitwise AND, 37 gives bitwise OR.
- R4: Function code 42 gives 1 in `result_o` when `opa_i` is less than the second operand as signed 32-bit values, and 0 otherwise.
- R5: Function code 0 shifts the second operand left by `imm_ext_i[10:6]`, and code 2 shifts it right logically (zero fill) by the same amount.
- R6: `use_imm_i` = 1 makes `imm_ext_i` the second operand; `use_imm_i` = 0 makes `opb_reg_i` the second operand.
- R7: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R8: `br_target_o` equals `pc_next_i + 4*imm_ext_i` modulo 256; it uses only `imm_ext_i[5:0]`.
- R9: Add and subtract wrap silently on overflow, and the signed and unsigned variants (32/33, 34/35) give identical results.
- R10: When `aluop_i[1]` is 1 and `funct_i` is not one of the nine listed codes, `result_o` is 0 and `zero_o` is 1.
- R11: The outputs are combinational functions of the data inputs; `clk_i` and `rst_ni` have no effect, including while `rst_ni` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used only by the bound checker |
| rst_ni | input | 1 | Active-low reset, used only by the bound checker |
| opa_i | input | 32 | First register operand |
| opb_reg_i | input | 32 | Second register operand |
| imm_ext_i | input | 32 | Sign-extended immediate (bits 10:6 hold the shift amount) |
| funct_i | input | 6 | Function field of register-format instructions |
| aluop_i | input | 2 | Instruction class from main decode (bit 1 register-format, bit 0 branch-equal) |
| use_imm_i | input | 1 | Selects the immediate as second operand |
| pc_next_i | input | 8 | Incremented program counter |
| result_o | output | 32 | Arithmetic/logic result |
| zero_o | output | 1 | High when the result is zero |
| br_target_o | output | 8 | Branch destination address |

## Verification
The hardest case to reach is a signed comparison whose answer differs from the unsigned one, and the same applies to an add or subtract that overflows. Only operand pairs of opposite sign or near the ±2^31 edge expose a wrong compare or a wrap bug, and uniformly random operands almost never land there. The stimulus therefore crosses a fixed set of boundary words (0, 1, all ones, the largest positive and most negative values, and mixed patterns) with every function code. Shifts are swept over all 32 distances. The branch adder is swept over the program counter range against negative and positive offsets.

// File: rtl/exec_stage_pkg.sv
package exec_stage_pkg;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_SLL,
        ALU_SRL,
        ALU_NOP
    } alu_fn_e;

    localparam int unsigned FUNCT_W = 6;
    localparam int unsigned CLASS_W = 2;

    localparam logic [FUNCT_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FUNCT_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FUNCT_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FUNCT_W-1:0] FN_ADDU = 6'd33;
    localparam logic [FUNCT_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FUNCT_W-1:0] FN_SUBU = 6'd35;
    localparam logic [FUNCT_W-1:0] FN_AND  = 6'd36;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'd37;
    localparam logic [FUNCT_W-1:0] FN_SLT  = 6'd42;

    localparam int unsigned SHAMT_LSB = 6;

endpackage

// File: rtl/exec_alu_decode.sv
module exec_alu_decode
    import exec_stage_pkg::*;
(
    input  logic [CLASS_W-1:0] class_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output alu_fn_e            fn_o
);

    alu_fn_e rfmt_fn_d;

    // second level: function field, only consulted for register format
    always_comb begin
        unique case (funct_i)
            FN_ADD, FN_ADDU: rfmt_fn_d = ALU_ADD;
            FN_SUB, FN_SUBU: rfmt_fn_d = ALU_SUB;
            FN_AND:          rfmt_fn_d = ALU_AND;
            FN_OR:           rfmt_fn_d = ALU_OR;
            FN_SLT:          rfmt_fn_d = ALU_SLT;
            FN_SLL:          rfmt_fn_d = ALU_SLL;
            FN_SRL:          rfmt_fn_d = ALU_SRL;
            default:         rfmt_fn_d = ALU_NOP;
        endcase
    end

    // first level: class code forces memory and branch operations
    always_comb begin
        if (class_i[1]) begin
            fn_o = rfmt_fn_d;
        end else if (class_i[0]) begin
            fn_o = ALU_SUB;
        end else begin
            fn_o = ALU_ADD;
        end
    end

endmodule

// File: rtl/exec_alu_core.sv
module exec_alu_core
    import exec_stage_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
    input  alu_fn_e             fn_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [SHAMT_W-1:0]  shamt_i,
    output logic [DATA_W-1:0]   y_o
);

    logic [DATA_W-1:0] sum_d;
    logic [DATA_W-1:0] diff_d;
    logic              lt_d;

    always_comb begin
        sum_d  = a_i + b_i;
        diff_d = a_i - b_i;
        lt_d   = $signed(a_i) < $signed(b_i);
    end

    always_comb begin
        y_o = '0;
        unique case (fn_i)
            ALU_ADD: y_o = sum_d;
            ALU_SUB: y_o = diff_d;
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_SLT: y_o[0] = lt_d;
            ALU_SLL: y_o = b_i << shamt_i;
            ALU_SRL: y_o = b_i >> shamt_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/exec_branch_adder.sv
module exec_branch_adder #(
    parameter int unsigned PC_W = 8,
    localparam int unsigned OFF_W = PC_W - 2
) (
    input  logic [PC_W-1:0]  pc_next_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  target_o
);

    logic [PC_W-1:0] scaled_d;

    always_comb begin
        scaled_d = {off_i, 2'b00};
        target_o = pc_next_i + scaled_d;
    end

endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_stage_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PC_W   = 8,
    localparam int unsigned SHAMT_W = $clog2(DATA_W),
    localparam int unsigned OFF_W   = PC_W - 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [DATA_W-1:0]    opa_i,
    input  logic [DATA_W-1:0]    opb_reg_i,
    input  logic [DATA_W-1:0]    imm_ext_i,
    input  logic [FUNCT_W-1:0]   funct_i,
    input  logic [CLASS_W-1:0]   aluop_i,
    input  logic                 use_imm_i,
    input  logic [PC_W-1:0]      pc_next_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 zero_o,
    output logic [PC_W-1:0]      br_target_o
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic [PC_W-1:0]   target;
    } exec_out_t;

    alu_fn_e           fn_d;
    logic [DATA_W-1:0] opb_d;
    logic [DATA_W-1:0] alu_y_d;
    logic [PC_W-1:0]   target_d;
    exec_out_t         out_d;

    // clock and reset are kept for the wrapper and the checker only
    logic unused_clk_rst;
    assign unused_clk_rst = clk_i ^ rst_ni;

    always_comb begin
        opb_d = use_imm_i ? imm_ext_i : opb_reg_i;
    end

    exec_alu_decode u_decode (
        .class_i (aluop_i),
        .funct_i (funct_i),
        .fn_o    (fn_d)
    );

    exec_alu_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .fn_i    (fn_d),
        .a_i     (opa_i),
        .b_i     (opb_d),
        .shamt_i (imm_ext_i[SHAMT_LSB +: SHAMT_W]),
        .y_o     (alu_y_d)
    );

    exec_branch_adder #(
        .PC_W (PC_W)
    ) u_bradd (
        .pc_next_i (pc_next_i),
        .off_i     (imm_ext_i[OFF_W-1:0]),
        .target_o  (target_d)
    );

    always_comb begin
        out_d.result = alu_y_d;
        out_d.zero   = (alu_y_d == '0);
        out_d.target = target_d;
    end

    assign result_o    = out_d.result;
    assign zero_o      = out_d.zero;
    assign br_target_o = out_d.target;

endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk
    import exec_stage_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PC_W   = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [DATA_W-1:0]    opa_i,
    input logic [DATA_W-1:0]    opb_reg_i,
    input logic [DATA_W-1:0]    imm_ext_i,
    input logic [FUNCT_W-1:0]   funct_i,
    input logic [CLASS_W-1:0]   aluop_i,
    input logic                 use_imm_i,
    input logic [PC_W-1:0]      pc_next_i,
    input logic [DATA_W-1:0]    result_o,
    input logic                 zero_o,
    input logic [PC_W-1:0]      br_target_o
);

    logic [DATA_W-1:0] chk_b;
    logic              chk_known;
    logic [PC_W-1:0]   chk_tgt;

    always_comb begin
        chk_b     = use_imm_i ? imm_ext_i : opb_reg_i;
        chk_known = (funct_i == FN_ADD) || (funct_i == FN_ADDU) ||
                    (funct_i == FN_SUB) || (funct_i == FN_SUBU) ||
                    (funct_i == FN_AND) || (funct_i == FN_OR)   ||
                    (funct_i == FN_SLT) || (funct_i == FN_SLL)  ||
                    (funct_i == FN_SRL);
        chk_tgt   = pc_next_i + PC_W'(imm_ext_i * 4);
    end

    a_r7_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o == (result_o == '0));

    a_r1_mem_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aluop_i == 2'b00) |-> (result_o == opa_i + chk_b));

    a_r2_beq_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aluop_i == 2'b01) |-> (zero_o == (opa_i == chk_b)));

    a_r4_slt_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aluop_i[1] && funct_i == FN_SLT) |-> (result_o[DATA_W-1:1] == '0));

    a_r8_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        br_target_o == chk_tgt);

    a_r10_unknown_funct: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (aluop_i[1] && !chk_known) |-> (zero_o && result_o == '0));

endmodule

bind exec_stage exec_stage_chk #(
    .DATA_W (DATA_W),
    .PC_W   (PC_W)
) u_exec_stage_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .opa_i       (opa_i),
    .opb_reg_i   (opb_reg_i),
    .imm_ext_i   (imm_ext_i),
    .funct_i     (funct_i),
    .aluop_i     (aluop_i),
    .use_imm_i   (use_imm_i),
    .pc_next_i   (pc_next_i),
    .result_o    (result_o),
    .zero_o      (zero_o),
    .br_target_o (br_target_o)
);

// File: tb/tb_exec_stage.sv
`timescale 1ns/1ps
module tb_exec_stage;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] opa_i = '0;
    logic [31:0] opb_reg_i = '0;
    logic [31:0] imm_ext_i = '0;
    logic [5:0]  funct_i = '0;
    logic [1:0]  aluop_i = '0;
    logic        use_imm_i = 1'b0;
    logic [7:0]  pc_next_i = '0;
    logic [31:0] result_o;
    logic        zero_o;
    logic [7:0]  br_target_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk_i = ~clk_i;

    exec_stage dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .opa_i       (opa_i),
        .opb_reg_i   (opb_reg_i),
        .imm_ext_i   (imm_ext_i),
        .funct_i     (funct_i),
        .aluop_i     (aluop_i),
        .use_imm_i   (use_imm_i),
        .pc_next_i   (pc_next_i),
        .result_o    (result_o),
        .zero_o      (zero_o),
        .br_target_o (br_target_o)
    );

    function automatic logic [31:0] model_result(input logic [1:0] cls, input logic [5:0] fn,
                                                 input logic [31:0] a, input logic [31:0] b,
                                                 input logic [4:0] sh);
        logic signed [32:0] sa;
        logic signed [32:0] sb;
        sa = {a[31], a};
        sb = {b[31], b};
        if (cls[1]) begin
            case (fn)
                6'd32, 6'd33: return 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
                6'd34, 6'd35: return 32'((64'(a) + 64'h1_0000_0000 - 64'(b)) % 64'h1_0000_0000);
                6'd36: return a & b;
                6'd37: return a | b;
                6'd42: return (sa < sb) ? 32'd1 : 32'd0;
                6'd0:  return 32'((64'(b) * (64'd1 << sh)) % 64'h1_0000_0000);
                6'd2:  return 32'(64'(b) / (64'd1 << sh));
                default: return 32'd0;
            endcase
        end else if (cls[0]) begin
            return 32'((64'(a) + 64'h1_0000_0000 - 64'(b)) % 64'h1_0000_0000);
        end
        return 32'((64'(a) + 64'(b)) % 64'h1_0000_0000);
    endfunction

    function automatic string tag_of(input logic [1:0] cls, input logic [5:0] fn);
        if (!cls[1]) return cls[0] ? "R2" : "R1";
        case (fn)
            6'd42:        return "R4";
            6'd0, 6'd2:   return "R5";
            6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37: return "R3";
            default:      return "R10";
        endcase
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] cls, input logic [5:0] fn, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] imm, input logic ui,
                         input logic [7:0] pc);
        @(posedge clk_i);
        #1;
        aluop_i = cls; funct_i = fn; opa_i = a; opb_reg_i = b;
        imm_ext_i = imm; use_imm_i = ui; pc_next_i = pc;
        @(negedge clk_i);
    endtask

    task automatic run_alu(input string req, input logic [1:0] cls, input logic [5:0] fn,
                           input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm,
                           input logic ui);
        logic [31:0] exp;
        apply(cls, fn, a, b, imm, ui, 8'h10);
        exp = model_result(cls, fn, a, ui ? imm : b, imm[10:6]);
        check32(req, result_o, exp);
        check32("R7", {31'd0, zero_o}, {31'd0, exp == 32'd0});
    endtask

    localparam logic [31:0] VALS [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                         32'h8000_0000, 32'h1234_5678, 32'hFFFF_0000, 32'h5};
    localparam logic [5:0] FNS [13] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36, 6'd37, 6'd42,
                                        6'd0, 6'd2, 6'd1, 6'd38, 6'd43, 6'd63};

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state and R11: outputs live while reset is held low
        @(negedge clk_i);
        check32("R11 reset state result", result_o, 32'd0);
        check32("R11 reset state zero", {31'd0, zero_o}, 32'd1);
        check32("R11 reset state target", {24'd0, br_target_o}, 32'd0);
        apply(2'b00, 6'd0, 32'd7, 32'd9, 32'd0, 1'b0, 8'd20);
        check32("R11 result under reset", result_o, 32'd16);
        check32("R11 target under reset", {24'd0, br_target_o}, 32'd20);
        repeat (2) @(posedge clk_i);
        #1 rst_ni = 1'b1;

        // R3/R4/R5/R10 sweep: every function code across boundary operand pairs
        for (int c = 0; c < 2; c++) begin
            for (int f = 0; f < 13; f++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        run_alu(tag_of(c ? 2'b11 : 2'b10, FNS[f]), c ? 2'b11 : 2'b10,
                                FNS[f], VALS[i], VALS[j], 32'h0000_0140, 1'b0);
                    end
                end
            end
        end

        // R5 shifts over every distance
        for (int s = 0; s < 32; s++) begin
            for (int j = 0; j < 8; j++) begin
                run_alu("R5 sll", 2'b10, 6'd0, 32'hDEAD_BEEF, VALS[j], 32'(s) << 6, 1'b0);
                run_alu("R5 srl", 2'b10, 6'd2, 32'hDEAD_BEEF, VALS[j], 32'(s) << 6, 1'b0);
            end
        end

        // R1 / R2 / R6 with both operand sources
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                run_alu("R1 R6 imm", 2'b00, 6'd13, VALS[i], 32'hAAAA_0000, VALS[j], 1'b1);
                run_alu("R1 R6 reg", 2'b00, 6'd13, VALS[i], VALS[j], 32'h0000_0FFF, 1'b0);
                run_alu("R2 R6 reg", 2'b01, 6'd32, VALS[i], VALS[j], 32'h0000_0004, 1'b0);
                run_alu("R2 R6 imm", 2'b01, 6'd32, VALS[i], 32'h5555_5555, VALS[j], 1'b1);
            end
        end

        // R2 explicit equal / unequal
        apply(2'b01, 6'd0, 32'hCAFE_0001, 32'hCAFE_0001, 32'd0, 1'b0, 8'd0);
        check32("R2 equal zero", {31'd0, zero_o}, 32'd1);
        apply(2'b01, 6'd0, 32'hCAFE_0001, 32'hCAFE_0002, 32'd0, 1'b0, 8'd0);
        check32("R2 unequal zero", {31'd0, zero_o}, 32'd0);

        // R9 overflow wraps, signed and unsigned variants match
        apply(2'b10, 6'd32, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R9 add wrap", result_o, 32'h8000_0000);
        apply(2'b10, 6'd33, 32'h7FFF_FFFF, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R9 addu wrap", result_o, 32'h8000_0000);
        apply(2'b10, 6'd34, 32'h8000_0000, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R9 sub wrap", result_o, 32'h7FFF_FFFF);
        apply(2'b10, 6'd35, 32'h8000_0000, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R9 subu wrap", result_o, 32'h7FFF_FFFF);
        apply(2'b10, 6'd32, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R9 R7 add to zero", {result_o[31:1], zero_o}, {31'd0, 1'b1});

        // R4 signed compare where unsigned would disagree
        apply(2'b10, 6'd42, 32'h8000_0000, 32'd1, 32'd0, 1'b0, 8'd0);
        check32("R4 neg lt pos", result_o, 32'd1);
        apply(2'b10, 6'd42, 32'd1, 32'hFFFF_FFFF, 32'd0, 1'b0, 8'd0);
        check32("R4 pos not lt neg", result_o, 32'd0);

        // R8 branch target sweep, negative and positive offsets
        for (int p = 0; p < 256; p += 17) begin
            for (int k = -40; k <= 40; k += 3) begin
                logic [31:0] imm;
                logic [7:0]  exp_t;
                imm   = 32'(k);
                exp_t = 8'((p + 4 * k + 1024) % 256);
                apply(2'b01, 6'd0, 32'd3, 32'd3, imm, 1'b0, 8'(p));
                check32("R8 target", {24'd0, br_target_o}, {24'd0, exp_t});
            end
        end

        // R11 reset re-asserted mid-run does not disturb outputs
        apply(2'b10, 6'd37, 32'hF0F0_0000, 32'h0000_0F0F, 32'd0, 1'b0, 8'd100);
        #1 rst_ni = 1'b0;
        @(negedge clk_i);
        check32("R11 or under reset", result_o, 32'hF0F0_0F0F);
        check32("R11 target under reset", {24'd0, br_target_o}, 32'd100);
        @(posedge clk_i);
        #1 rst_ni = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule